// File: doc/BRIEF.md
# Cartridge ROM Bank-Switching Mapper

This block sits between the cartridge edge connector of an 8-bit processor system and a large parallel ROM plus a two-wire serial EEPROM. The processor sees a 32 KB window through a 15-bit address bus. The lowest 24 KB of that window reach the start of the ROM unchanged. The next 4 KB show any one 4 KB page of the ROM, chosen by a bank register. The top 4 KB are kept for control registers and never enable the ROM.

The cartridge counts as selected while at least one of its four active-low region enables is low. Address decoding, ROM address forming and read-back data are purely combinational. Register writes are sampled by a local system clock: the write strobe passes through a synchronizer, and each assertion of the strobe produces exactly one register update. The EEPROM clock line is a push-pull output. The EEPROM data line is open-drain: the block only reports when the line should be pulled low. The level on the data pin is synchronized before it is read back.

Top module: `cart_mapper`

## Requirements
- R1: When all four active-low enables `sel_n` are high, `rom_ce_n` is 1 and `cart_data_oe` is 0. Any single low enable selects the cartridge.
- R2: While selected, addresses 0x0000 to 0x5FFF give `rom_ce_n` = 0 and `rom_addr` equal to the address zero-extended to 18 bits.
- R3: While selected, addresses 0x6000 to 0x6FFF give `rom_ce_n` = 0 and `rom_addr` = {bank[5:0], address[11:0]}. Every bank value is allowed, including banks 0 to 5, which overlap the fixed region.
- R4: Addresses 0x7000 to 0x7FFF never enable the ROM (`rom_ce_n` = 1).
- R5: The 6-bit bank register resets to 0. A selected write to 0x7000 loads it from data bits [5:0].
- R6: A selected write to 0x7001 sets `eep_scl` from data bit 0 and the EEPROM data line from data bit 1. On the data line, 1 means released (`eep_sda_low` = 0) and 0 means pulled low (`eep_sda_low` = 1). After reset both lines are released and high.
- R7: A read of 0x7000 returns {2'b00, bank}. A read of 0x7001 returns 0xFC OR (synchronized `eep_sda_in` << 1) OR `eep_scl`. A read of any other register address returns 0xFF. The EEPROM data input appears in the read value two clock edges after it changes.
- R8: `cart_data_oe` is 1 exactly when the cartridge is selected, `rd_n` is 0 and the address is in 0x7000 to 0x7FFF.
- R9: A write to 0x7002 to 0x7FFF, or to any address below 0x7000, changes no register.
- R10: A write takes effect on the third rising clock edge after `wr_n` falls. Only one write happens per low period of `wr_n`, so a data change later in the same strobe has no effect.
- R11: A write strobe while no enable is low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for register capture (at least 8 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cart_addr | input | 15 | Cartridge address bus |
| cart_data_in | input | 8 | Cartridge data bus, value driven by the processor |
| cart_data_out | output | 8 | Register read data |
| cart_data_oe | output | 1 | Drive enable for the cartridge data bus |
| sel_n | input | 4 | Active-low region enables |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe, asynchronous to clk |
| rom_addr | output | 18 | Address to the external ROM |
| rom_ce_n | output | 1 | Active-low ROM chip enable |
| eep_scl | output | 1 | EEPROM clock line |
| eep_sda_low | output | 1 | When 1, the EEPROM data line is pulled low |
| eep_sda_in | input | 1 | Level sensed on the EEPROM data line |

## Verification
The bench builds the block with its default parameters: a 15-bit window, an 18-bit ROM address, a 6-bit bank and two synchronizer stages. These values place all three regions, every register offset and the overlap of the banked page with the fixed region within reach of directed stimulus. Writing bank 0x3F and bank 0 exercises the highest and lowest ROM pages. Long write strobes in which the data changes show the one-write-per-strobe rule. A behavioural model counts clock edges, so the three-edge write latency and the two-edge input latency are checked cycle by cycle.

// File: rtl/cm_pkg.sv
package cm_pkg;
    typedef enum logic [1:0] {
        RG_FIXED = 2'd0,
        RG_BANK  = 2'd1,
        RG_CTRL  = 2'd2
    } region_e;

    // Register offsets inside the control region (decoded by the bench too)
    localparam int OFS_BANK = 0;
    localparam int OFS_EEP  = 1;
endpackage

// File: rtl/cm_sync.sv
module cm_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = din;
        for (int i = 1; i < STAGES; i++) sh_d[i] = sh_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/cm_decode.sv
module cm_decode import cm_pkg::*; #(
    parameter int ADDR_W = 15,
    parameter int SEL_N  = 4,
    parameter int ROM_AW = 18,
    parameter int BANK_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEL_N-1:0]  sel_n,
    input  logic [BANK_W-1:0] bank,
    output logic              selected,
    output region_e           region,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_ce_n
);
    localparam int PAGE_W = ADDR_W - 3;

    always_comb begin
        selected = ~&sel_n;
        if (addr[ADDR_W-1:ADDR_W-2] != 2'b11) region = RG_FIXED;
        else if (addr[PAGE_W])                region = RG_CTRL;
        else                                  region = RG_BANK;

        unique case (region)
            RG_FIXED: rom_addr = ROM_AW'(addr);
            RG_BANK:  rom_addr = {bank, addr[PAGE_W-1:0]};
            default:  rom_addr = '0;
        endcase
        rom_ce_n = ~(selected && (region != RG_CTRL));
    end
endmodule

// File: rtl/cm_regs.sv
module cm_regs import cm_pkg::*; #(
    parameter int PAGE_W = 12,
    parameter int BANK_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n_s,
    input  logic              sda_s,
    input  logic              selected,
    input  region_e           region,
    input  logic [PAGE_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] wdata,
    output logic [BANK_W-1:0] bank,
    output logic              scl,
    output logic              sda_rel,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              scl;
        logic              sda;
        logic              wr_prev;
    } st_t;

    st_t  st_d, st_q;
    logic take;

    always_comb begin
        st_d         = st_q;
        st_d.wr_prev = wr_n_s;
        take = st_q.wr_prev && !wr_n_s && selected && (region == RG_CTRL);
        if (take) begin
            if (addr_lo == PAGE_W'(OFS_BANK)) st_d.bank = wdata[BANK_W-1:0];
            if (addr_lo == PAGE_W'(OFS_EEP)) begin
                st_d.scl = wdata[0];
                st_d.sda = wdata[1];
            end
        end

        if (addr_lo == PAGE_W'(OFS_BANK))     rdata = DATA_W'(st_q.bank);
        else if (addr_lo == PAGE_W'(OFS_EEP)) rdata = {{(DATA_W-2){1'b1}}, sda_s, st_q.scl};
        else                                  rdata = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bank: '0, scl: 1'b1, sda: 1'b1, wr_prev: 1'b1};
        else        st_q <= st_d;
    end

    assign bank    = st_q.bank;
    assign scl     = st_q.scl;
    assign sda_rel = st_q.sda;

    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);                                                   // R10
    AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(st_q.bank) && $stable(st_q.scl) && $stable(st_q.sda)); // R9
    AST_HIGH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && addr_lo > PAGE_W'(OFS_EEP)) |=> $stable(st_q.bank) && $stable(st_q.scl) && $stable(st_q.sda)); // R9
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper import cm_pkg::*; #(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int SEL_N       = 4,
    parameter int ROM_AW      = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cart_addr,
    input  logic [DATA_W-1:0] cart_data_in,
    output logic [DATA_W-1:0] cart_data_out,
    output logic              cart_data_oe,
    input  logic [SEL_N-1:0]  sel_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              eep_scl,
    output logic              eep_sda_low,
    input  logic              eep_sda_in
);
    localparam int PAGE_W  = ADDR_W - 3;
    localparam int BANK_W  = ROM_AW - PAGE_W;
    localparam int FIX_TOP = 3 << (ADDR_W - 2);
    localparam int CTL_BOT = 7 << (ADDR_W - 3);

    logic              selected;
    region_e           region;
    logic [BANK_W-1:0] bank;
    logic              sda_rel;
    logic [1:0]        sync_out;

    cm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({wr_n, eep_sda_in}), .dout(sync_out)
    );

    cm_decode #(.ADDR_W(ADDR_W), .SEL_N(SEL_N), .ROM_AW(ROM_AW), .BANK_W(BANK_W)) u_dec (
        .addr(cart_addr), .sel_n(sel_n), .bank(bank), .selected(selected),
        .region(region), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n)
    );

    cm_regs #(.PAGE_W(PAGE_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_n_s(sync_out[1]), .sda_s(sync_out[0]),
        .selected(selected), .region(region), .addr_lo(cart_addr[PAGE_W-1:0]),
        .wdata(cart_data_in), .bank(bank), .scl(eep_scl), .sda_rel(sda_rel),
        .rdata(cart_data_out)
    );

    assign cart_data_oe = selected && !rd_n && (region == RG_CTRL);
    assign eep_sda_low  = ~sda_rel;

    AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&sel_n) |-> rom_ce_n && !cart_data_oe);                           // R1
    AST_FIXED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&sel_n) && int'(cart_addr) < FIX_TOP) |-> !rom_ce_n && rom_addr == ROM_AW'(cart_addr)); // R2
    AST_BANK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&sel_n) && int'(cart_addr) >= FIX_TOP && int'(cart_addr) < CTL_BOT)
            |-> rom_addr[ROM_AW-1:PAGE_W] == bank);                        // R3
    AST_CTRL_NO_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cart_addr) >= CTL_BOT) |-> rom_ce_n);                        // R4
    AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> !cart_data_oe);                                           // R8
endmodule

// File: tb/sim_cart_mapper.sv
`timescale 1ns/100ps
module sim_cart_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] cart_addr = '0;
    logic [7:0]  cart_data_in = '0;
    logic [7:0]  cart_data_out;
    logic        cart_data_oe;
    logic [3:0]  sel_n = 4'hF;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [17:0] rom_addr;
    logic        rom_ce_n;
    logic        eep_scl;
    logic        eep_sda_low;
    logic        eep_sda_in = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    cart_mapper u0 (.*);

    // behavioural reference state
    int m_bank = 0, m_scl = 1, m_sda = 1, m_sda_seen = 1, wr_age = 0;
    int sda_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bank = 0; m_scl = 1; m_sda = 1; m_sda_seen = 1; wr_age = 0;
            sda_q.delete();
        end else begin
            if (sda_q.size() == 2) void'(sda_q.pop_front());
            sda_q.push_back(int'(eep_sda_in));
            if (sda_q.size() == 2) m_sda_seen = sda_q[0];
            wr_age = wr_n ? 0 : wr_age + 1;
            if (wr_age == 3 && sel_n != 4'hF) begin   // R10: third edge
                if (cart_addr == 15'h7000) m_bank = cart_data_in & 8'h3F;
                if (cart_addr == 15'h7001) begin
                    m_scl = cart_data_in[0];
                    m_sda = cart_data_in[1];
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            int a;
            bit sel;
            a   = int'(cart_addr);
            sel = (sel_n != 4'hF);
            if (!sel)            chk("R1 ce", int'(rom_ce_n), 1);
            else if (a >= 'h7000) chk("R4 ce", int'(rom_ce_n), 1);
            else begin
                chk(a < 'h6000 ? "R2 ce" : "R3 ce", int'(rom_ce_n), 0);
                if (a < 'h6000) chk("R2 addr", int'(rom_addr), a);
                else            chk("R3 addr", int'(rom_addr), m_bank * 4096 + (a & 'hFFF));
            end
            chk("R8 oe", int'(cart_data_oe), int'(sel && !rd_n && a >= 'h7000));
            if (cart_data_oe) begin
                if (a == 'h7000)      chk("R7 bank rd", int'(cart_data_out), m_bank);
                else if (a == 'h7001) chk("R7 eep rd", int'(cart_data_out), 'hFC | (m_sda_seen << 1) | m_scl);
                else                  chk("R7 other rd", int'(cart_data_out), 'hFF);
            end
            chk("R6 scl", int'(eep_scl), m_scl);
            chk("R6 sda", int'(eep_sda_low), int'(m_sda == 0));
        end
    end

    task automatic drive(input logic [14:0] a, input logic [3:0] s, input logic r);
        @(negedge clk);
        cart_addr = a; sel_n = s; rd_n = r;
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d, input logic [3:0] s);
        @(negedge clk);
        cart_addr = a; cart_data_in = d; sel_n = s; rd_n = 1'b1; wr_n = 1'b0;
        repeat (5) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        sel_n = 4'hF;
    endtask

    task automatic rd_chk(input logic [14:0] a, input string tag, input int exp);
        drive(a, 4'b1110, 1'b0);
        #1 chk(tag, int'(cart_data_out), exp);
        drive(a, 4'hF, 1'b1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // reset state: R5, R6
        rd_chk(15'h7000, "R5 reset bank", 0);
        #1 chk("R6 reset scl", int'(eep_scl), 1);
        chk("R6 reset sda", int'(eep_sda_low), 0);
        drive(15'h6ABC, 4'b0111, 1'b1);
        #1 chk("R3 bank0 page", int'(rom_addr), 'h00ABC);
        // each single enable selects: R1
        for (int i = 0; i < 4; i++) begin
            drive(15'h1234, ~(4'b1 << i), 1'b1);
            #1 chk("R1 single enable", int'(rom_ce_n), 0);
        end
        drive(15'h1234, 4'hF, 1'b0);
        #1 chk("R1 unselected oe", int'(cart_data_oe), 0);
        // fixed region edges: R2
        drive(15'h0000, 4'b1101, 1'b0);
        #1 chk("R2 low edge", int'(rom_addr), 0);
        drive(15'h5FFF, 4'b1101, 1'b0);
        #1 chk("R2 high edge", int'(rom_addr), 'h5FFF);
        // bank writes: R5, R3
        wr(15'h7000, 8'hFF, 4'b1011);
        drive(15'h6FFF, 4'b1011, 1'b0);
        #1 chk("R3 top page", int'(rom_addr), 'h3FFFF);
        wr(15'h7000, 8'h02, 4'b0111);
        drive(15'h6010, 4'b0111, 1'b0);
        #1 chk("R3 overlap page", int'(rom_addr), 'h02010);
        rd_chk(15'h7000, "R5 readback", 2);
        // register region never enables ROM: R4
        drive(15'h7FFF, 4'b0000, 1'b0);
        #1 chk("R4 top", int'(rom_ce_n), 1);
        // ignored writes: R9, R11
        wr(15'h7002, 8'h15, 4'b1110);
        wr(15'h7FFF, 8'h00, 4'b1110);
        wr(15'h6000, 8'h15, 4'b1110);
        rd_chk(15'h7000, "R9 bank kept", 2);
        rd_chk(15'h7001, "R9 eep kept", 'hFF);
        wr(15'h7000, 8'h2A, 4'hF);
        rd_chk(15'h7000, "R11 unselected write", 2);
        // EEPROM lines: R6, R7
        wr(15'h7001, 8'h00, 4'b1110);
        #1 chk("R6 scl low", int'(eep_scl), 0);
        chk("R6 sda pulled", int'(eep_sda_low), 1);
        wr(15'h7001, 8'h02, 4'b1110);
        chk("R6 sda released", int'(eep_sda_low), 0);
        @(negedge clk); eep_sda_in = 1'b0;
        repeat (3) @(negedge clk);
        rd_chk(15'h7001, "R7 sda low sensed", 'hFC);
        @(negedge clk); eep_sda_in = 1'b1;
        repeat (3) @(negedge clk);
        rd_chk(15'h7001, "R7 sda high sensed", 'hFE);
        rd_chk(15'h7123, "R7 other addr", 'hFF);
        // one write per strobe, data changes mid-strobe: R10
        @(negedge clk);
        cart_addr = 15'h7000; cart_data_in = 8'h11; sel_n = 4'b1110; wr_n = 1'b0;
        @(negedge clk);
        #1 chk("R10 not yet", int'(u0.bank), 2);
        repeat (4) @(negedge clk);
        cart_data_in = 8'h22;
        repeat (10) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        sel_n = 4'hF;
        rd_chk(15'h7000, "R10 first data only", 'h11);
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule